// File: doc/BRIEF.md
# Pixel Column Hit Sparsifier

This block turns the raw per-pixel front-end outputs of one pixel column into a sparse stream of hit words. Each pixel delivers a 7-bit thermometer code from its flash comparators and a separate hit flag from an independent discriminator. The block reduces every thermometer code to a 3-bit amplitude and drops hits from pixels whose mask bit is set. Surviving hits are gathered into a capture latch set over one bunch-crossing period. At the next period boundary they move into a scan set, from which a priority encoder emits one word per accepted cycle, lowest address first.

A period boundary is marked by `frameTick`, a one-cycle strobe synchronous to `clk` that stands in for the bunch-crossing clock. Hits that arrive while a scan is running fill the capture set and wait for the following boundary. A period without hits yields no words. Words not taken before the next boundary are discarded. The default column holds 48 pixels, and four such instances serve a 192-pixel group of columns. Output words leave through a valid/ready handshake.

Top module: `pixColSparsifier`

## Requirements
- R1: A pixel's amplitude equals the number of consecutive ones in its thermometer code counted upward from bit 0; for example 0000000 gives 0, 1111111 gives 7, 0000101 gives 1 and 1111110 gives 0. Pixel p uses bits `thermIn[p*7 +: 7]`.
- R2: Only the hit flag creates a word: a hit with an all-zero thermometer code produces a word with amplitude 0, and a nonzero code without a hit produces none.
- R3: A write with `maskWe` high sets the mask bit of pixel `maskAddr` to `maskVal`; a write to an address of 48 or more changes nothing; a hit on a pixel whose mask bit is set when the hit is sampled produces no word.
- R4: A hit sampled during a frame appears on the output only after the `frameTick` that closes that frame; a frame without hits produces no words.
- R5: Within a frame, words leave in ascending pixel address, one per cycle in which `outValid` and `outReady` are both high, and each hit pixel yields exactly one word.
- R6: `outData[8:3]` holds the pixel address and `outData[2:0]` the amplitude.
- R7: While `outValid` is high and `outReady` is low, and no `frameTick` occurs, `outValid` and `outData` stay unchanged in the next cycle.
- R8: Hits sampled after a frame's closing `frameTick`, including those sampled in the same cycle as that `frameTick`, are not merged into that frame's scan; they belong to the next frame.
- R9: At a `frameTick` the words of the previous frame that were not accepted are discarded; a word accepted in the same cycle as the `frameTick` counts as delivered, and the scan set then holds exactly the new frame's hits.
- R10: If a pixel is hit more than once in a frame, its word carries the amplitude of the first hit.
- R11: After reset no word is valid, all mask bits are clear and both latch sets are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameTick | input | 1 | One-cycle strobe closing the current bunch-crossing frame |
| thermIn | input | 336 | Thermometer codes, 7 bits per pixel, pixel p at bits p*7 +: 7 |
| hitIn | input | 48 | Per-pixel hit flags from the separate discriminator |
| maskWe | input | 1 | Mask write strobe |
| maskAddr | input | 6 | Pixel address of the mask write |
| maskVal | input | 1 | New mask bit value (1 = masked) |
| outValid | output | 1 | A hit word is present on outData |
| outReady | input | 1 | Downstream takes the word in this cycle |
| outData | output | 9 | Hit word: address in bits 8:3, amplitude in bits 2:0 |

## Verification
The two functions that can fall in one cycle are the acceptance of a word and the frame boundary that reloads the scan set; a second overlap is a new hit sampled in the very cycle of that boundary. The bench raises `outReady` and `frameTick` in the same cycle while an older, lower-addressed word and a later word are pending, then judges that the next word shown is the new frame's hit and that the older leftover never reappears. It likewise drives a hit together with `frameTick` and expects that pixel only after the following boundary, while a lower-addressed hit arriving mid-scan must not overtake the word being presented.

// File: rtl/pixSparsePkg.sv
package pixSparsePkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadFrame; // move capture set into scan set, restart capture
    logic popWord;   // clear the request of the word being accepted
  } sparseStrobe_t;

  localparam int DEF_NUM_PIX = 48;
  localparam int DEF_THERM_W = 7;
  localparam int DEF_AMP_W   = 3;

endpackage

// File: rtl/thermEncoder.sv
module thermEncoder #(
  parameter int THERM_W = 7,
  parameter int AMP_W   = 3
) (
  input  logic [THERM_W-1:0] therm,
  output logic [AMP_W-1:0]   amp
);

  // Amplitude is the index of the lowest zero, i.e. the length of the
  // run of ones starting at bit 0; a full code gives THERM_W.
  always_comb begin
    amp = AMP_W'(THERM_W);
    for (int i = THERM_W - 1; i >= 0; i--) begin
      if (!therm[i]) amp = AMP_W'(i);
    end
  end

endmodule

// File: rtl/prioEnc.sv
module prioEnc #(
  parameter int N     = 48,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Lowest set request wins: scan downward so the last hit is the lowest.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign found = |req;

endmodule

// File: rtl/sparseCtrl.sv
module sparseCtrl
  import pixSparsePkg::*;
(
  input  logic          frameTick,
  input  logic          anyPend,
  input  logic          outReady,
  output logic          outValid,
  output sparseStrobe_t strobe
);

  assign outValid         = anyPend;
  assign strobe.loadFrame = frameTick;
  assign strobe.popWord   = anyPend & outReady;

endmodule

// File: rtl/sparseDatapath.sv
module sparseDatapath
  import pixSparsePkg::*;
#(
  parameter int NUM_PIX = DEF_NUM_PIX,
  parameter int THERM_W = DEF_THERM_W,
  parameter int AMP_W   = DEF_AMP_W,
  parameter int ADDR_W  = $clog2(NUM_PIX),
  localparam int WORD_W = ADDR_W + AMP_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PIX*THERM_W-1:0] thermIn,
  input  logic [NUM_PIX-1:0]         hitIn,
  input  logic                       maskWe,
  input  logic [ADDR_W-1:0]          maskAddr,
  input  logic                       maskVal,
  input  sparseStrobe_t              strobe,
  output logic                       anyPend,
  output logic [WORD_W-1:0]          wordOut
);

  logic [NUM_PIX-1:0] maskBits;
  logic [NUM_PIX-1:0] pendVec;
  logic [AMP_W-1:0]   scanAmpArr [NUM_PIX];
  logic [ADDR_W-1:0]  selIdx;

  // Mask configuration; out-of-range addresses are dropped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskBits <= '0;
    end else if (maskWe && (int'(maskAddr) < NUM_PIX)) begin
      maskBits[maskAddr] <= maskVal;
    end
  end

  for (genvar p = 0; p < NUM_PIX; p++) begin : g_pix
    logic [AMP_W-1:0] liveAmp;
    logic             liveHit;
    logic             capHit;
    logic [AMP_W-1:0] capAmp;
    logic             pend;
    logic [AMP_W-1:0] scanAmp;

    thermEncoder #(.THERM_W(THERM_W), .AMP_W(AMP_W)) u_enc (
      .therm(thermIn[p*THERM_W +: THERM_W]),
      .amp  (liveAmp)
    );

    assign liveHit = hitIn[p] & ~maskBits[p];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        capHit  <= 1'b0;
        capAmp  <= '0;
        pend    <= 1'b0;
        scanAmp <= '0;
      end else if (strobe.loadFrame) begin
        // Closed frame moves to scan; this cycle's hit opens the next frame
        pend    <= capHit;
        scanAmp <= capAmp;
        capHit  <= liveHit;
        capAmp  <= liveHit ? liveAmp : '0;
      end else begin
        if (liveHit && !capHit) begin
          capHit <= 1'b1;
          capAmp <= liveAmp;
        end
        if (strobe.popWord && (selIdx == ADDR_W'(p))) begin
          pend <= 1'b0;
        end
      end
    end

    assign pendVec[p]    = pend;
    assign scanAmpArr[p] = scanAmp;
  end

  prioEnc #(.N(NUM_PIX), .IDX_W(ADDR_W)) u_prio (
    .req  (pendVec),
    .found(anyPend),
    .idx  (selIdx)
  );

  assign wordOut = {selIdx, scanAmpArr[selIdx]};

endmodule

// File: rtl/pixColSparsifier.sv
module pixColSparsifier
  import pixSparsePkg::*;
#(
  parameter int NUM_PIX = DEF_NUM_PIX,
  parameter int THERM_W = DEF_THERM_W,
  parameter int AMP_W   = DEF_AMP_W,
  localparam int ADDR_W = $clog2(NUM_PIX),
  localparam int WORD_W = ADDR_W + AMP_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       frameTick,
  input  logic [NUM_PIX*THERM_W-1:0] thermIn,
  input  logic [NUM_PIX-1:0]         hitIn,
  input  logic                       maskWe,
  input  logic [ADDR_W-1:0]          maskAddr,
  input  logic                       maskVal,
  output logic                       outValid,
  input  logic                       outReady,
  output logic [WORD_W-1:0]          outData
);

  sparseStrobe_t strobe;
  logic          anyPend;

  sparseCtrl u_ctrl (
    .frameTick(frameTick),
    .anyPend  (anyPend),
    .outReady (outReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  sparseDatapath #(
    .NUM_PIX(NUM_PIX),
    .THERM_W(THERM_W),
    .AMP_W  (AMP_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .thermIn (thermIn),
    .hitIn   (hitIn),
    .maskWe  (maskWe),
    .maskAddr(maskAddr),
    .maskVal (maskVal),
    .strobe  (strobe),
    .anyPend (anyPend),
    .wordOut (outData)
  );

endmodule

// File: rtl/sparseChk.sv
module sparseChk #(
  parameter int NUM_PIX = 48,
  parameter int ADDR_W  = 6,
  parameter int WORD_W  = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameTick,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outData
);

  logic              seenFrame;
  logic              haveLast;
  logic [ADDR_W-1:0] lastAddr;
  logic [ADDR_W-1:0] curAddr;

  assign curAddr = outData[WORD_W-1 -: ADDR_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenFrame <= 1'b0;
      haveLast  <= 1'b0;
      lastAddr  <= '0;
    end else begin
      if (frameTick) seenFrame <= 1'b1;
      if (frameTick) begin
        haveLast <= 1'b0;
      end else if (outValid && outReady) begin
        haveLast <= 1'b1;
        lastAddr <= curAddr;
      end
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !frameTick) |=> (outValid && $stable(outData)));

  // R4
  no_word_before_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    !seenFrame |-> !outValid);

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (int'(curAddr) < NUM_PIX));

  // R5
  ascending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && haveLast) |-> (curAddr > lastAddr));

endmodule

bind pixColSparsifier sparseChk #(
  .NUM_PIX(NUM_PIX),
  .ADDR_W (ADDR_W),
  .WORD_W (WORD_W)
) u_sparseChk (
  .clk      (clk),
  .rstN     (rstN),
  .frameTick(frameTick),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData)
);

// File: tb/test_pixColSparsifier.sv
module test_pixColSparsifier;
  localparam int NP  = 48;
  localparam int TW  = 7;
  localparam int AW  = 3;
  localparam int ADW = 6;

  logic           clk = 1'b0;
  logic           rstN;
  logic           frameTick;
  logic [NP*TW-1:0] thermIn;
  logic [NP-1:0]  hitIn;
  logic           maskWe;
  logic [ADW-1:0] maskAddr;
  logic           maskVal;
  logic           outValid;
  logic           outReady;
  logic [ADW+AW-1:0] outData;

  always #4 clk = ~clk;

  pixColSparsifier i_pixColSparsifier (
    .clk(clk), .rstN(rstN), .frameTick(frameTick), .thermIn(thermIn),
    .hitIn(hitIn), .maskWe(maskWe), .maskAddr(maskAddr), .maskVal(maskVal),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  int  nCmp = 0;
  int  nBad = 0;
  bit  finished = 0;
  bit  sbOn = 1;
  logic [ADW+AW-1:0] expQ [$];
  bit       mHit  [NP];
  logic [AW-1:0] mAmp [NP];
  bit       mMask [NP];

  function automatic logic [AW-1:0] refAmp(logic [TW-1:0] t);
    int n = 0;
    for (int k = 0; k < TW; k++) begin
      if (!t[k]) break;
      n++;
    end
    return AW'(n);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compares accepted words with the scoreboard queue
  always @(negedge clk) begin
    if (rstN && sbOn && outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 R4 unexpected word", 32'(outData), 32'h1ff);
      end else begin
        logic [ADW+AW-1:0] e;
        e = expQ.pop_front();
        check(outData == e, "R5 R6 word order and content", 32'(outData), 32'(e));
      end
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    hitIn     = '0;
    thermIn   = '0;
    frameTick = 1'b0;
    maskWe    = 1'b0;
  endtask

  task automatic stage(int p, logic [TW-1:0] t);
    hitIn[p] = 1'b1;
    thermIn[p*TW +: TW] = t;
    if (!mMask[p] && !mHit[p]) begin
      mHit[p] = 1'b1;
      mAmp[p] = refAmp(t);
    end
  endtask

  task automatic stageTherm(int p, logic [TW-1:0] t);
    thermIn[p*TW +: TW] = t;
  endtask

  // Close the frame in the model and raise frameTick; caller then steps
  task automatic tickPrep();
    for (int i = 0; i < NP; i++) begin
      if (mHit[i]) expQ.push_back({ADW'(i), mAmp[i]});
      mHit[i] = 1'b0;
    end
    frameTick = 1'b1;
  endtask

  task automatic tick();
    tickPrep();
    step();
  endtask

  task automatic maskWr(int a, bit v);
    maskAddr = ADW'(a);
    maskVal  = v;
    maskWe   = 1'b1;
    if (a < NP) mMask[a] = v;
    step();
  endtask

  task automatic drain(string req);
    outReady = 1'b1;
    repeat (NP + 4) step();
    outReady = 1'b0;
    check(expQ.size() == 0, req, 32'(expQ.size()), 32'd0);
    check(outValid == 1'b0, req, 32'(outValid), 32'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; frameTick = 1'b0; thermIn = '0; hitIn = '0;
    maskWe = 1'b0; maskAddr = '0; maskVal = 1'b0; outReady = 1'b0;
    for (int i = 0; i < NP; i++) begin
      mHit[i] = 1'b0; mAmp[i] = '0; mMask[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    check(outValid == 1'b0, "R11 no word after reset", 32'(outValid), 32'd0);
    tick();
    check(outValid == 1'b0, "R4 R11 empty frame gives no word", 32'(outValid), 32'd0);

    // R1 R2 encoding and hit independence
    stage(0, 7'b1111111);
    stage(47, 7'b0000000);
    stage(20, 7'b0000101);
    stage(21, 7'b0000011);
    stage(22, 7'b1111110);
    stageTherm(30, 7'b0011111);
    step();
    check(outValid == 1'b0, "R4 hits wait for frame close", 32'(outValid), 32'd0);
    tick();
    check(outData == {6'd0, 3'd7}, "R1 R6 first word format", 32'(outData), 32'({6'd0, 3'd7}));
    drain("R1 R2 frame drained");

    // R10 first hit amplitude kept
    stage(9, 7'b0011111);
    step();
    stage(9, 7'b0000011);
    step();
    tick();
    check(outData == {6'd9, 3'd5}, "R10 first amplitude kept", 32'(outData), 32'({6'd9, 3'd5}));
    drain("R10 frame drained");

    // R3 masking, out-of-range write ignored
    maskWr(7, 1'b1);
    maskWr(50, 1'b1);
    stage(7, 7'b1111111);
    stage(8, 7'b0000011);
    stage(2, 7'b0000001);
    stage(18, 7'b0001111);
    step();
    tick();
    drain("R3 masked pixel silent");
    maskWr(7, 1'b0);
    stage(7, 7'b0001111);
    step();
    tick();
    check(outData == {6'd7, 3'd4}, "R3 unmasked pixel returns", 32'(outData), 32'({6'd7, 3'd4}));
    drain("R3 frame drained");

    // R5 ordering of several hits in one cycle and across cycles
    stage(40, 7'b0000111);
    stage(1, 7'b0111111);
    stage(33, 7'b0000000);
    step();
    stage(12, 7'b0000001);
    stage(46, 7'b1111111);
    step();
    tick();
    check(outData == {6'd1, 3'd6}, "R5 lowest address first", 32'(outData), 32'({6'd1, 3'd6}));
    drain("R5 frame drained");

    // R7 R8 hold under back-pressure, late lower hit not merged
    stage(4, 7'b0111111);
    step();
    tick();
    stage(2, 7'b1111111);
    step();
    repeat (3) step();
    check(outValid && outData == {6'd4, 3'd6}, "R7 R8 word held, late hit not merged",
          32'(outData), 32'({6'd4, 3'd6}));
    // R9 unaccepted word 4 discarded; R8 hit at boundary goes to next frame
    expQ.delete();
    tickPrep();
    stage(6, 7'b0000111);
    step();
    check(outData == {6'd2, 3'd7}, "R8 R9 new frame without boundary hit",
          32'(outData), 32'({6'd2, 3'd7}));
    drain("R8 R9 frame drained");
    tick();
    check(outData == {6'd6, 3'd3}, "R8 boundary hit in following frame",
          32'(outData), 32'({6'd6, 3'd3}));
    drain("R8 frame drained");

    // R9 acceptance coinciding with frameTick
    sbOn = 1'b0;
    stage(3, 7'b0001111);
    stage(10, 7'b0000001);
    step();
    tick();
    expQ.delete();
    stage(5, 7'b0111111);
    step();
    check(outData == {6'd3, 3'd4}, "R9 old frame word shown", 32'(outData), 32'({6'd3, 3'd4}));
    outReady = 1'b1;
    tickPrep();
    step();
    outReady = 1'b0;
    check(outValid && outData == {6'd5, 3'd6}, "R9 scan holds only new frame",
          32'(outData), 32'({6'd5, 3'd6}));
    outReady = 1'b1;
    step();
    outReady = 1'b0;
    check(outValid == 1'b0, "R9 leftover word discarded", 32'(outValid), 32'd0);
    expQ.delete();
    sbOn = 1'b1;

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule